// File: doc/BRIEF.md
# External Bus Visibility Gating Controller

This block sits between a processor's internal bus and the pins of its multiplexed external bus. On every clock, which is one internal bus cycle, it decides what the external pins show. The pins are the E strobe, the read/write line, the address, the data and the low-byte strobe. The decision depends on the operating mode, a visibility enable bit, a secure flag and the kind of cycle in progress: an ordinary access, a cycle that selects the debug module, or a cycle in which the CPU makes no access. Every pin value is registered, so a pin that is blocked keeps the value it showed last.

The block also owns a 3-bit mode register. Writes to this register are refused while the part is secure, and reserved codes are never loaded. The block masks the two instruction-pipe status outputs when the part is secure. A stop request freezes the whole block, and only a reset releases it.

Top module: `ebv_gate_ctrl`

## Requirements
- R1: The mode codes are single-chip 000, expanded narrow 001, expanded wide 011, peripheral 100, emulation narrow 101 and emulation wide 111. Visibility can take effect only when the registered mode is 011, 101 or 111. In 000, 001 and 100 a cycle behaves as a hidden cycle whatever the value of `vis_en_i`.
- R2: In a hidden cycle (visibility not in effect), after the next clock `e_o` is 0 and `rw_o` is 1. `addr_o`, `data_o` and `lstrb_o` keep their previous values.
- R3: In an ordinary cycle with visibility in effect (`dbg_sel_i`=0, `no_acc_i`=0), after the next clock `e_o` is 1. `rw_o`, `addr_o`, `data_o` and `lstrb_o` equal the internal values sampled at that clock.
- R4: In a debug-select cycle with visibility in effect (`dbg_sel_i`=1, which takes priority over `no_acc_i`), after the next clock `e_o` is 0, `rw_o` is 1 and `data_o` is held. `addr_o` and `lstrb_o` take the internal values.
- R5: In a no-access cycle with visibility in effect (`no_acc_i`=1, `dbg_sel_i`=0), after the next clock `e_o` is 0, `rw_o` is 1 and address, data and strobe are all held.
- R6: While `secure_i` is 1, `vis_en_i` has no effect and every cycle behaves as a hidden cycle in every mode.
- R7: One clock after a cycle, `pipe_o` equals `pipe_stat_i` when `pipe_en_i`=1 and `secure_i`=0. Otherwise it is 0; in particular it is 0 when the pipe outputs are enabled and the part is secure.
- R8: A write (`mode_we_i`=1) loads `mode_wdata_i` into `mode_o` at the next clock. The write is ignored while `secure_i` is 1 or when the code is reserved (010 or 110). A cycle that coincides with a mode write is judged with the mode in force before that write.
- R9: From the clock at which `stop_i` is 1, and for every later clock until reset, no output changes, whatever the inputs do.
- R10: During and after reset, `e_o`=0, `rw_o`=1, `addr_o`, `data_o`, `lstrb_o` and `pipe_o` are 0, and `mode_o` equals the `RESET_MODE` parameter (default 000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one internal bus cycle per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Stop request; freezes the block until reset |
| secure_i | input | 1 | Part is in secure state |
| mode_we_i | input | 1 | Write strobe for the mode field |
| mode_wdata_i | input | 3 | Mode code to write |
| vis_en_i | input | 1 | Internal visibility enable bit |
| dbg_sel_i | input | 1 | Current cycle selects the debug module |
| no_acc_i | input | 1 | CPU makes no access this cycle |
| int_addr_i | input | ADDR_W | Internal address |
| int_data_i | input | DATA_W | Internal data |
| int_lstrb_i | input | 1 | Internal low-byte strobe |
| int_rw_i | input | 1 | Internal read/write (1 = read) |
| pipe_en_i | input | 1 | Instruction-pipe status outputs enabled |
| pipe_stat_i | input | 2 | Instruction-pipe status from the core |
| e_o | output | 1 | External E strobe |
| rw_o | output | 1 | External read/write |
| addr_o | output | ADDR_W | External address |
| data_o | output | DATA_W | External data |
| lstrb_o | output | 1 | External low-byte strobe |
| pipe_o | output | 2 | Masked instruction-pipe status |
| mode_o | output | 3 | Current mode register value |

## Verification
A mode write and a bus cycle can land on the same clock. The cycle must then be judged under the old mode, while the new mode governs only the next cycle. The bench provokes this by writing each mode code in a cycle that carries a visible-style access, with random dbg and no-access bits. Its model computes the pin outcome from the mode it held before applying the write. A stop request can also coincide with a cycle that would otherwise update pins. The bench raises stop together with a visible access and a mode write, and expects none of the three to take effect.

// File: rtl/ebv_pkg.sv
package ebv_pkg;

  typedef enum logic [2:0] {
    MD_SINGLE     = 3'b000,
    MD_EXP_NARROW = 3'b001,
    MD_RSVD_A     = 3'b010,
    MD_EXP_WIDE   = 3'b011,
    MD_PERIPH     = 3'b100,
    MD_EMU_NARROW = 3'b101,
    MD_RSVD_B     = 3'b110,
    MD_EMU_WIDE   = 3'b111
  } ebv_mode_e;

  typedef enum logic [1:0] {
    CY_HIDDEN = 2'd0,
    CY_OPEN   = 2'd1,
    CY_DEBUG  = 2'd2,
    CY_IDLE   = 2'd3
  } ebv_cyc_e;

  localparam int MODE_W = 3;
  localparam int PIPE_W = 2;

  function automatic logic mode_is_legal(input logic [MODE_W-1:0] code);
    return (code != MD_RSVD_A) && (code != MD_RSVD_B);
  endfunction

  function automatic logic mode_allows_vis(input ebv_mode_e md);
    return (md == MD_EXP_WIDE) || (md == MD_EMU_NARROW) || (md == MD_EMU_WIDE);
  endfunction

endpackage

// File: rtl/ebv_mode_reg.sv
module ebv_mode_reg
  import ebv_pkg::*;
#(
  parameter ebv_mode_e RESET_MODE = MD_SINGLE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_i,
  input  logic              secure_i,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wdata_i,
  output ebv_mode_e         mode_o
);

  ebv_mode_e mode_q;
  ebv_mode_e mode_d;
  logic      load_en;

  always_comb begin
    load_en = we_i && !secure_i && !freeze_i && mode_is_legal(wdata_i);
    mode_d  = ebv_mode_e'(wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RESET_MODE;
    end else if (load_en) begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

  AST_SECURE_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (secure_i && we_i) |=> $stable(mode_q)); // R8

  AST_RSVD_MODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && ((wdata_i == MD_RSVD_A) || (wdata_i == MD_RSVD_B))) |=> $stable(mode_q)); // R8

  AST_MODE_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !secure_i && !freeze_i && (wdata_i == MD_EXP_WIDE)) |=> (mode_q == MD_EXP_WIDE)); // R8

endmodule

// File: rtl/ebv_cycle_class.sv
module ebv_cycle_class
  import ebv_pkg::*;
(
  input  ebv_mode_e mode_i,
  input  logic      vis_en_i,
  input  logic      secure_i,
  input  logic      dbg_sel_i,
  input  logic      no_acc_i,
  output ebv_cyc_e  cls_o,
  output logic      vis_eff_o
);

  logic vis_eff;

  always_comb begin
    vis_eff = vis_en_i && !secure_i && mode_allows_vis(mode_i);
    if (!vis_eff) begin
      cls_o = CY_HIDDEN;
    end else if (dbg_sel_i) begin
      cls_o = CY_DEBUG;
    end else if (no_acc_i) begin
      cls_o = CY_IDLE;
    end else begin
      cls_o = CY_OPEN;
    end
  end

  assign vis_eff_o = vis_eff;

endmodule

// File: rtl/ebv_pin_hold.sv
module ebv_pin_hold
  import ebv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_i,
  input  ebv_cyc_e          cls_i,
  input  logic [ADDR_W-1:0] int_addr_i,
  input  logic [DATA_W-1:0] int_data_i,
  input  logic              int_lstrb_i,
  input  logic              int_rw_i,
  output logic              e_o,
  output logic              rw_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              lstrb_o
);

  logic              e_q, e_d;
  logic              rw_q, rw_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              lstrb_q;
  logic              ctl_en;
  logic              addr_en;
  logic              data_en;

  always_comb begin
    ctl_en  = !freeze_i;
    addr_en = 1'b0;
    data_en = 1'b0;
    e_d     = 1'b0;
    rw_d    = 1'b1;
    unique case (cls_i)
      CY_OPEN: begin
        e_d     = 1'b1;
        rw_d    = int_rw_i;
        addr_en = !freeze_i;
        data_en = !freeze_i;
      end
      CY_DEBUG: begin
        addr_en = !freeze_i;
      end
      CY_IDLE: begin
        addr_en = 1'b0;
      end
      default: begin
        addr_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q  <= 1'b0;
      rw_q <= 1'b1;
    end else if (ctl_en) begin
      e_q  <= e_d;
      rw_q <= rw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      lstrb_q <= 1'b0;
    end else if (addr_en) begin
      addr_q  <= int_addr_i;
      lstrb_q <= int_lstrb_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= int_data_i;
    end
  end

  assign e_o     = e_q;
  assign rw_o    = rw_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
  assign lstrb_o = lstrb_q;

  AST_HIDDEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == CY_HIDDEN && !freeze_i) |=>
      (!e_q && rw_q && $stable(addr_q) && $stable(data_q) && $stable(lstrb_q))); // R2

  AST_OPEN_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == CY_OPEN && !freeze_i) |=>
      (e_q && rw_q == $past(int_rw_i) && addr_q == $past(int_addr_i) &&
       data_q == $past(int_data_i) && lstrb_q == $past(int_lstrb_i))); // R3

  AST_DEBUG_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == CY_DEBUG && !freeze_i) |=>
      (!e_q && rw_q && $stable(data_q) && addr_q == $past(int_addr_i) &&
       lstrb_q == $past(int_lstrb_i))); // R4

  AST_IDLE_ALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == CY_IDLE && !freeze_i) |=>
      (!e_q && rw_q && $stable(addr_q) && $stable(data_q) && $stable(lstrb_q))); // R5

endmodule

// File: rtl/ebv_pipe_mask.sv
module ebv_pipe_mask
  import ebv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_i,
  input  logic              secure_i,
  input  logic              pipe_en_i,
  input  logic [PIPE_W-1:0] stat_i,
  output logic [PIPE_W-1:0] pipe_o
);

  logic [PIPE_W-1:0] pipe_q;
  logic [PIPE_W-1:0] pipe_d;
  logic              show;

  always_comb begin
    show   = pipe_en_i && !secure_i;
    pipe_d = show ? stat_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else if (!freeze_i) begin
      pipe_q <= pipe_d;
    end
  end

  assign pipe_o = pipe_q;

  AST_SECURE_PIPE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (secure_i && !freeze_i) |=> (pipe_q == '0)); // R7

endmodule

// File: rtl/ebv_gate_ctrl.sv
module ebv_gate_ctrl
  import ebv_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         DATA_W     = 16,
  parameter logic [2:0] RESET_MODE = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_i,
  input  logic              secure_i,
  input  logic              mode_we_i,
  input  logic [2:0]        mode_wdata_i,
  input  logic              vis_en_i,
  input  logic              dbg_sel_i,
  input  logic              no_acc_i,
  input  logic [ADDR_W-1:0] int_addr_i,
  input  logic [DATA_W-1:0] int_data_i,
  input  logic              int_lstrb_i,
  input  logic              int_rw_i,
  input  logic              pipe_en_i,
  input  logic [1:0]        pipe_stat_i,
  output logic              e_o,
  output logic              rw_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              lstrb_o,
  output logic [1:0]        pipe_o,
  output logic [2:0]        mode_o
);

  logic      stopped_q;
  logic      stopped_d;
  logic      freeze;
  ebv_mode_e mode_cur;
  ebv_cyc_e  cls;
  logic      vis_eff;

  always_comb begin
    stopped_d = stopped_q | stop_i;
    freeze    = stopped_q | stop_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopped_q <= 1'b0;
    end else begin
      stopped_q <= stopped_d;
    end
  end

  ebv_mode_reg #(
    .RESET_MODE (ebv_mode_e'(RESET_MODE))
  ) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze_i (freeze),
    .secure_i (secure_i),
    .we_i     (mode_we_i),
    .wdata_i  (mode_wdata_i),
    .mode_o   (mode_cur)
  );

  ebv_cycle_class u_class (
    .mode_i    (mode_cur),
    .vis_en_i  (vis_en_i),
    .secure_i  (secure_i),
    .dbg_sel_i (dbg_sel_i),
    .no_acc_i  (no_acc_i),
    .cls_o     (cls),
    .vis_eff_o (vis_eff)
  );

  ebv_pin_hold #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .freeze_i    (freeze),
    .cls_i       (cls),
    .int_addr_i  (int_addr_i),
    .int_data_i  (int_data_i),
    .int_lstrb_i (int_lstrb_i),
    .int_rw_i    (int_rw_i),
    .e_o         (e_o),
    .rw_o        (rw_o),
    .addr_o      (addr_o),
    .data_o      (data_o),
    .lstrb_o     (lstrb_o)
  );

  ebv_pipe_mask u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze_i  (freeze),
    .secure_i  (secure_i),
    .pipe_en_i (pipe_en_i),
    .stat_i    (pipe_stat_i),
    .pipe_o    (pipe_o)
  );

  assign mode_o = mode_cur;

  AST_NARROW_MODES_HIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_cur == MD_SINGLE || mode_cur == MD_EXP_NARROW || mode_cur == MD_PERIPH) && !freeze)
      |=> (!e_o && rw_o && $stable(data_o))); // R1

  AST_SECURE_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
    (secure_i && !freeze) |=> (!e_o && rw_o && $stable(addr_o) && $stable(data_o))); // R6

  AST_VIS_ONLY_WHEN_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    vis_eff |-> (vis_en_i && !secure_i)); // R6

  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(e_o) && $stable(rw_o) && $stable(addr_o) && $stable(data_o) &&
                $stable(lstrb_o) && $stable(pipe_o) && $stable(mode_o))); // R9

endmodule

// File: tb/ebv_gate_ctrl_bench.sv
module ebv_gate_ctrl_bench;

  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic          stop_i, secure_i, mode_we_i, vis_en_i, dbg_sel_i, no_acc_i;
  logic [2:0]    mode_wdata_i;
  logic [AW-1:0] int_addr_i;
  logic [DW-1:0] int_data_i;
  logic          int_lstrb_i, int_rw_i, pipe_en_i;
  logic [1:0]    pipe_stat_i;
  logic          e_o, rw_o, lstrb_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] data_o;
  logic [1:0]    pipe_o;
  logic [2:0]    mode_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  logic          m_e, m_rw, m_lstrb, m_stop;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  logic [1:0]    m_pipe;
  logic [2:0]    m_mode;

  ebv_gate_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RESET_MODE(3'b000)) u_ebv_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .secure_i(secure_i),
    .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i), .vis_en_i(vis_en_i),
    .dbg_sel_i(dbg_sel_i), .no_acc_i(no_acc_i), .int_addr_i(int_addr_i),
    .int_data_i(int_data_i), .int_lstrb_i(int_lstrb_i), .int_rw_i(int_rw_i),
    .pipe_en_i(pipe_en_i), .pipe_stat_i(pipe_stat_i), .e_o(e_o), .rw_o(rw_o),
    .addr_o(addr_o), .data_o(data_o), .lstrb_o(lstrb_o), .pipe_o(pipe_o),
    .mode_o(mode_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string sig, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, sig, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string req);
    chk(req, "e",     int'(e_o),     int'(m_e));
    chk(req, "rw",    int'(rw_o),    int'(m_rw));
    chk(req, "addr",  int'(addr_o),  int'(m_addr));
    chk(req, "data",  int'(data_o),  int'(m_data));
    chk(req, "lstrb", int'(lstrb_o), int'(m_lstrb));
    chk(req, "pipe",  int'(pipe_o),  int'(m_pipe));
    chk(req, "mode",  int'(mode_o),  int'(m_mode));
  endtask

  // behavioural model of one clock edge, using the inputs now on the pins
  task automatic model_step();
    logic vis;
    if (m_stop || stop_i) begin
      m_stop = 1'b1;
      return;
    end
    vis = vis_en_i && !secure_i &&
          (m_mode == 3'b011 || m_mode == 3'b101 || m_mode == 3'b111);
    if (!vis) begin
      m_e = 1'b0; m_rw = 1'b1;
    end else if (dbg_sel_i) begin
      m_e = 1'b0; m_rw = 1'b1; m_addr = int_addr_i; m_lstrb = int_lstrb_i;
    end else if (no_acc_i) begin
      m_e = 1'b0; m_rw = 1'b1;
    end else begin
      m_e = 1'b1; m_rw = int_rw_i; m_addr = int_addr_i;
      m_data = int_data_i; m_lstrb = int_lstrb_i;
    end
    m_pipe = (pipe_en_i && !secure_i) ? pipe_stat_i : 2'b00;
    if (mode_we_i && !secure_i && mode_wdata_i != 3'b010 && mode_wdata_i != 3'b110)
      m_mode = mode_wdata_i;
  endtask

  task automatic drive(input string req, input logic we, input logic [2:0] wd,
                       input logic vis, input logic sec, input logic dbg,
                       input logic noacc, input logic pen, input logic stop);
    mode_we_i    = we;
    mode_wdata_i = wd;
    vis_en_i     = vis;
    secure_i     = sec;
    dbg_sel_i    = dbg;
    no_acc_i     = noacc;
    pipe_en_i    = pen;
    pipe_stat_i  = 2'($urandom);
    stop_i       = stop;
    int_addr_i   = AW'($urandom);
    int_data_i   = DW'($urandom);
    int_lstrb_i  = 1'($urandom);
    int_rw_i     = 1'($urandom);
    model_step();
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    logic [2:0] codes [5];
    codes[0] = 3'b000; codes[1] = 3'b001; codes[2] = 3'b100;
    codes[3] = 3'b101; codes[4] = 3'b111;
    rst_n = 1'b0;
    {stop_i, secure_i, mode_we_i, vis_en_i, dbg_sel_i, no_acc_i} = '0;
    mode_wdata_i = '0; int_addr_i = '0; int_data_i = '0;
    int_lstrb_i = 1'b0; int_rw_i = 1'b0; pipe_en_i = 1'b0; pipe_stat_i = '0;
    m_e = 1'b0; m_rw = 1'b1; m_addr = '0; m_data = '0; m_lstrb = 1'b0;
    m_pipe = '0; m_mode = 3'b000; m_stop = 1'b0;
    repeat (3) @(negedge clk);
    compare_all("R10");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R10");

    // mode write, then visible ordinary traffic
    drive("R8", 1'b1, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (10) drive("R3", 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (8)  drive("R4", 1'b0, 3'b000, 1'b1, 1'b0, 1'b1, 1'($urandom), 1'b0, 1'b0);
    repeat (6)  drive("R5", 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (6)  drive("R2", 1'b0, 3'b000, 1'b0, 1'b0, 1'($urandom), 1'($urandom), 1'b0, 1'b0);

    // every legal mode; the write cycle itself is judged under the old mode
    for (int k = 0; k < 5; k++) begin
      drive("R8", 1'b1, codes[k], 1'b1, 1'b0, 1'($urandom), 1'($urandom), 1'b0, 1'b0);
      repeat (5) drive("R1", 1'b0, 3'b000, 1'b1, 1'b0, 1'($urandom), 1'($urandom), 1'b0, 1'b0);
    end

    // reserved codes are not loaded (mode stays 111)
    drive("R8", 1'b1, 3'b010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R8", 1'b1, 3'b110, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R8", 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // secure: visibility bit ignored
    repeat (8) drive("R6", 1'b0, 3'b000, 1'b1, 1'b1, 1'($urandom), 1'($urandom), 1'b0, 1'b0);

    // pipe status masking
    repeat (6) drive("R7", 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (6) drive("R7", 1'b0, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (4) drive("R7", 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // secure write refused, then leave secure and check mode is still 111
    drive("R8", 1'b1, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R8", 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      drive("R3", 1'(($urandom % 8) == 0), 3'($urandom), 1'(($urandom % 4) != 0),
            1'(($urandom % 6) == 0), 1'(($urandom % 4) == 0), 1'(($urandom % 4) == 0),
            1'($urandom), 1'b0);
    end

    // stop coincides with a visible access and a mode write
    drive("R8", 1'b1, 3'b011, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    drive("R9", 1'b1, 3'b101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) begin
      drive("R9", 1'b1, 3'($urandom), 1'b1, 1'b0, 1'($urandom), 1'b0, 1'b1, 1'b0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule